// File: doc/BRIEF.md
# Clock-Divide Power Mode Controller

This block owns the speed setting of a microcontroller core. The core can run at a fast rate of four oscillator clocks per machine cycle, or in one of two low-power rates of 64 or 1024 oscillator clocks per machine cycle. From that setting the block makes two strobes. One is a time-base enable that the core's timers and watchdog use as their clock enable. The other is a machine-cycle strobe. Because the watchdog uses the same time base, it slows down by the same factor in the low-power rates.

Software changes the setting through a small write port, and the block checks each request before accepting it. A change between the two low-power rates must pass through the fast rate; any other request is dropped and the setting stays as it was. When the hardware switchback is armed, a qualified wake event pulls the core out of either low-power rate without software action. A new rate takes effect only at the end of a machine cycle. The block also qualifies the external reset pin, and the method depends on the rate. At the fast rate the pin must stay high for a fixed time. At the low-power rates a rising edge is enough, because holding the pin for two slow machine cycles would take thousands of clocks.

Top module: `clkdiv_pmm_ctrl`

## Requirements
- R1: The applied rate code `cur_div` uses this encoding: 01 gives 4 oscillator clocks per machine cycle, 10 gives 64, and 11 gives 1024. Code 00 is reserved and never applied. After reset `cur_div` is 01, and `mc_stb` is high for one clock at the end of each machine cycle.
- R2: In every rate, `tb_en` pulses exactly 4 times per machine cycle: every clock at code 01, every 16 clocks at 10, and every 256 clocks at 11. The last of the 4 pulses falls in the same clock as `mc_stb`.
- R3: A write whose code keeps the setting the same is accepted. A write that moves between 01 and 10, or between 01 and 11, is also accepted.
- R4: A write of code 00 is ignored, and so is a write that moves directly between 10 and 11. The setting keeps its previous value.
- R5: `cur_div` changes only in the clock after a `mc_stb` pulse. The first machine cycle at the new rate has its full length.
- R6: A write loads the switchback enable from `cfg_sben`; the enable is 0 after reset. While the enable is 1 and the setting is 10 or 11, a `wake_evt` pulse sets the setting to 01. This takes priority over a write in the same clock.
- R7: A `wake_evt` pulse has no effect while the switchback enable is 0.
- R8: At rate 01, the reset pin passes through a two-flop synchroniser. `rst_out` goes high only after the synchronised pin has been high for 8 consecutive clocks, which is two machine cycles. If the pin goes high before clock edge k, `rst_out` is high after edge k+9. A shorter pulse never raises `rst_out`.
- R9: At rate 10 or 11, a rising edge of the synchronised pin raises `rst_out` after edge k+2. `rst_out` then stays high until the synchronised pin is low again.
- R10: While `rst_out` is high, the setting is forced to 01 and the switchback enable is cleared.
- R11: `sts_busy` repeats `busy_in` one clock later. A busy flag does not block writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cfg_we | input | 1 | Write strobe for the setting |
| cfg_div | input | 2 | Requested rate code |
| cfg_sben | input | 1 | Switchback enable written with each write |
| wake_evt | input | 1 | Qualified wake event |
| rst_pin | input | 1 | Asynchronous external reset pin |
| busy_in | input | 1 | A timing-dependent operation is in progress |
| cur_div | output | 2 | Applied rate code |
| tb_en | output | 1 | Time-base enable, one clock wide |
| mc_stb | output | 1 | Machine-cycle end strobe |
| rst_out | output | 1 | Qualified reset |
| sts_busy | output | 1 | Registered busy status |

## Verification
The bench goes after the transition table with seeded random writes, including the forbidden 10 to 11 and 11 to 10 jumps and the reserved code. A design that did not filter these would reach a slow rate with no fast step in between. It also times the first machine cycle after a rate change, which exposes a divider that applies the new rate mid-cycle or that skips its counter restart. The reset tests use a short pin pulse at each rate. A design that picks the wrong qualifier would either miss the pulse at a low-power rate or accept a glitch at the fast rate. The bench also checks the exact edge on which `rst_out` rises, which catches a wrong synchroniser depth or an off-by-one qualification count. The switchback test applies a write and a wake event in the same clock, which catches a design that gives the write priority.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

    typedef enum logic [1:0] {
        DIV_RSVD = 2'b00,
        DIV_FAST = 2'b01,
        DIV_LP1  = 2'b10,
        DIV_LP2  = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic     we;
        div_sel_e div;
        logic     sb_en;
    } cfg_wr_t;

    function automatic logic is_low_power(div_sel_e m);
        return (m == DIV_LP1) || (m == DIV_LP2);
    endfunction

    // A move is allowed only if it keeps the setting or one side is the fast rate
    function automatic logic step_ok(div_sel_e from_m, div_sel_e to_m);
        if (to_m == DIV_RSVD)
            return 1'b0;
        if (to_m == from_m)
            return 1'b1;
        return (from_m == DIV_FAST) || (to_m == DIV_FAST);
    endfunction

endpackage

// File: rtl/pmm_mode_reg.sv
module pmm_mode_reg
    import pmm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_wr_t  wr,
    input  logic     wake,
    input  logic     qual_rst,
    output div_sel_e set_q
);
    logic sb_q;

    always_ff @(posedge clk) begin
        if (rst || qual_rst) begin
            set_q <= DIV_FAST;
            sb_q  <= 1'b0;
        end else begin
            if (wr.we)
                sb_q <= wr.sb_en;
            // hardware switchback outranks a software write in the same clock
            if (sb_q && wake && is_low_power(set_q))
                set_q <= DIV_FAST;
            else if (wr.we && step_ok(set_q, wr.div))
                set_q <= wr.div;
        end
    end

endmodule

// File: rtl/pmm_divider.sv
module pmm_divider
    import pmm_pkg::*;
#(
    parameter int unsigned FAST_N   = 4,
    parameter int unsigned LP1_N    = 64,
    parameter int unsigned LP2_N    = 1024,
    parameter int unsigned MC_TICKS = 4,
    localparam int unsigned CNT_W   = $clog2(LP2_N)
) (
    input  logic     clk,
    input  logic     rst,
    input  div_sel_e set_q,
    output div_sel_e cur_q,
    output logic     mc_stb,
    output logic     tb_en
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] sub_mask;

    function automatic int unsigned div_ratio(div_sel_e m);
        case (m)
            DIV_LP1: return LP1_N;
            DIV_LP2: return LP2_N;
            default: return FAST_N;
        endcase
    endfunction

    assign lim      = CNT_W'(div_ratio(cur_q) - 1);
    assign sub_mask = CNT_W'(div_ratio(cur_q) / MC_TICKS - 1);
    assign mc_stb   = (cnt == lim);
    assign tb_en    = ((cnt & sub_mask) == sub_mask);

    // rate is only swapped at a cycle end, where the counter restarts from zero
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cur_q <= DIV_FAST;
        end else if (mc_stb) begin
            cnt   <= '0;
            cur_q <= set_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pmm_rst_qual.sv
module pmm_rst_qual #(
    parameter int unsigned SYNC_N    = 2,
    parameter int unsigned QUAL_CLKS = 8,
    localparam int unsigned HW       = $clog2(QUAL_CLKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fast_mode,
    output logic qual
);
    logic [SYNC_N-1:0] sync_q;
    logic              rs;
    logic              rs_d;
    logic [HW-1:0]     hi_cnt;
    logic              edge_lat;

    assign rs = sync_q[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            rs_d     <= 1'b0;
            hi_cnt   <= '0;
            edge_lat <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            rs_d   <= rs;
            if (!rs)
                hi_cnt <= '0;
            else if (hi_cnt != HW'(QUAL_CLKS))
                hi_cnt <= hi_cnt + 1'b1;
            if (!rs)
                edge_lat <= 1'b0;
            else if (!fast_mode && !rs_d)
                edge_lat <= 1'b1;
        end
    end

    assign qual = edge_lat || (fast_mode && (hi_cnt == HW'(QUAL_CLKS)));

endmodule

// File: rtl/clkdiv_pmm_ctrl.sv
module clkdiv_pmm_ctrl
    import pmm_pkg::*;
#(
    parameter int unsigned FAST_N   = 4,
    parameter int unsigned LP1_N    = 64,
    parameter int unsigned LP2_N    = 1024,
    parameter int unsigned MC_TICKS = 4,
    parameter int unsigned QUAL_MC  = 2,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_div,
    input  logic       cfg_sben,
    input  logic       wake_evt,
    input  logic       rst_pin,
    input  logic       busy_in,
    output logic [1:0] cur_div,
    output logic       tb_en,
    output logic       mc_stb,
    output logic       rst_out,
    output logic       sts_busy
);
    localparam int unsigned QUAL_CLKS = QUAL_MC * FAST_N;

    cfg_wr_t  wr;
    div_sel_e set_q;
    div_sel_e cur_q;

    assign wr.we    = cfg_we;
    assign wr.div   = div_sel_e'(cfg_div);
    assign wr.sb_en = cfg_sben;

    pmm_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .wake     (wake_evt),
        .qual_rst (rst_out),
        .set_q    (set_q)
    );

    pmm_divider #(
        .FAST_N   (FAST_N),
        .LP1_N    (LP1_N),
        .LP2_N    (LP2_N),
        .MC_TICKS (MC_TICKS)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .set_q  (set_q),
        .cur_q  (cur_q),
        .mc_stb (mc_stb),
        .tb_en  (tb_en)
    );

    pmm_rst_qual #(
        .SYNC_N    (SYNC_N),
        .QUAL_CLKS (QUAL_CLKS)
    ) u_rq (
        .clk       (clk),
        .rst       (rst),
        .pin       (rst_pin),
        .fast_mode (cur_q == DIV_FAST),
        .qual      (rst_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sts_busy <= 1'b0;
        else
            sts_busy <= busy_in;
    end

    assign cur_div = cur_q;

endmodule

// File: rtl/pmm_ctrl_chk.sv
module pmm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cur_div,
    input logic       mc_stb,
    input logic       tb_en,
    input logic       rst_out,
    input logic       rst_pin,
    input logic       busy_in,
    input logic       sts_busy
);
    logic [7:0] pin_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_pin)
            pin_cnt <= '0;
        else if (pin_cnt != 8'hFF)
            pin_cnt <= pin_cnt + 1'b1;
    end

    assert_no_reserved_R1: assert property (@(posedge clk) disable iff (rst)
        cur_div != 2'b00);

    assert_tb_with_mc_R2: assert property (@(posedge clk) disable iff (rst)
        mc_stb |-> tb_en);

    assert_via_fast_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_div) |-> (cur_div == 2'b01 || $past(cur_div) == 2'b01));

    assert_change_at_edge_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_div) |-> $past(mc_stb));

    assert_level_qual_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_out) && $past(cur_div) == 2'b01) |-> (pin_cnt >= 8'd10));

    assert_busy_echo_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sts_busy == $past(busy_in)));

endmodule

bind clkdiv_pmm_ctrl pmm_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cur_div  (cur_div),
    .mc_stb   (mc_stb),
    .tb_en    (tb_en),
    .rst_out  (rst_out),
    .rst_pin  (rst_pin),
    .busy_in  (busy_in),
    .sts_busy (sts_busy)
);

// File: tb/clkdiv_pmm_ctrl_tb.sv
module clkdiv_pmm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_div = 2'b01;
    logic       cfg_sben = 1'b0;
    logic       wake_evt = 1'b0;
    logic       rst_pin = 1'b0;
    logic       busy_in = 1'b0;
    logic [1:0] cur_div;
    logic       tb_en, mc_stb, rst_out, sts_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkdiv_pmm_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_sben(cfg_sben), .wake_evt(wake_evt), .rst_pin(rst_pin),
        .busy_in(busy_in), .cur_div(cur_div), .tb_en(tb_en),
        .mc_stb(mc_stb), .rst_out(rst_out), .sts_busy(sts_busy)
    );

    function automatic int ratio_of(logic [1:0] c);
        return (c == 2'b11) ? 1024 : (c == 2'b10) ? 64 : 4;
    endfunction

    function automatic bit move_ok(logic [1:0] a, logic [1:0] b);
        case ({a, b})
            4'b0101, 4'b1010, 4'b1111,
            4'b0110, 4'b0111, 4'b1001, 4'b1101: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] code, logic sb);
        cfg_we = 1'b1; cfg_div = code; cfg_sben = sb;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic wait_apply();
        for (int i = 0; i < 1100; i++) begin
            if (mc_stb) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic measure(int exp_len, string req);
        int n = 0;
        int tbc = 0;
        for (int i = 0; i < 1100; i++) begin
            if (mc_stb) break;
            @(negedge clk);
        end
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            n++;
            tbc += int'(tb_en);
            if (mc_stb) break;
        end
        check(n == exp_len, req, n, exp_len);
        check(tbc == 4, "R2", tbc, 4);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [1:0] exp_div;
        int n;
        bit seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and fast rate
        check(cur_div == 2'b01, "R1", cur_div, 1);
        check(rst_out == 1'b0, "R1", rst_out, 0);
        measure(4, "R1");

        // R3 legal moves, R4 illegal moves
        wr(2'b10, 1'b0); wait_apply();
        check(cur_div == 2'b10, "R3", cur_div, 2);
        measure(64, "R1");
        wr(2'b11, 1'b0); wait_apply();
        check(cur_div == 2'b10, "R4", cur_div, 2);
        wr(2'b00, 1'b0); wait_apply();
        check(cur_div == 2'b10, "R4", cur_div, 2);
        wr(2'b01, 1'b0); wait_apply();
        check(cur_div == 2'b01, "R3", cur_div, 1);
        wr(2'b11, 1'b0); wait_apply();
        check(cur_div == 2'b11, "R3", cur_div, 3);
        measure(1024, "R1");

        // R5 change waits for boundary, first cycle full length
        wr(2'b01, 1'b0);
        repeat (10) @(negedge clk);
        check(cur_div == 2'b11, "R5", cur_div, 3);
        wait_apply();
        check(cur_div == 2'b01, "R5", cur_div, 1);
        n = 1;
        for (int i = 0; i < 20; i++) begin
            if (mc_stb) break;
            @(negedge clk);
            n++;
        end
        check(n == 4, "R5", n, 4);

        // R6 switchback, also beating a same-clock write
        wr(2'b10, 1'b1); wait_apply();
        pulse_wake(); wait_apply();
        check(cur_div == 2'b01, "R6", cur_div, 1);
        wr(2'b11, 1'b1); wait_apply();
        cfg_we = 1'b1; cfg_div = 2'b11; cfg_sben = 1'b1; wake_evt = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; wake_evt = 1'b0;
        wait_apply();
        check(cur_div == 2'b01, "R6", cur_div, 1);

        // R7 wake ignored when switchback disarmed
        wr(2'b10, 1'b0); wait_apply();
        pulse_wake(); wait_apply();
        check(cur_div == 2'b10, "R7", cur_div, 2);

        // R11 busy echo, write accepted while busy
        busy_in = 1'b1;
        @(negedge clk);
        check(sts_busy == 1'b1, "R11", sts_busy, 1);
        wr(2'b01, 1'b0); wait_apply();
        check(cur_div == 2'b01, "R11", cur_div, 1);
        busy_in = 1'b0;
        @(negedge clk);
        check(sts_busy == 1'b0, "R11", sts_busy, 0);

        // R8 short pulse at fast rate is filtered
        rst_pin = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            seen |= rst_out;
        end
        rst_pin = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            seen |= rst_out;
        end
        check(seen == 1'b0, "R8", seen, 0);
        // R8 held pin, exact qualification edge
        rst_pin = 1'b1;
        repeat (9) @(negedge clk);
        check(rst_out == 1'b0, "R8", rst_out, 0);
        @(negedge clk);
        check(rst_out == 1'b1, "R8", rst_out, 1);
        rst_pin = 1'b0;
        repeat (5) @(negedge clk);
        check(rst_out == 1'b0, "R8", rst_out, 0);

        // R9 edge detect at low-power rate, R10 forced back to fast
        wr(2'b10, 1'b0); wait_apply();
        check(cur_div == 2'b10, "R9", cur_div, 2);
        rst_pin = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_out == 1'b0, "R9", rst_out, 0);
        @(negedge clk);
        check(rst_out == 1'b1, "R9", rst_out, 1);
        rst_pin = 1'b0;
        repeat (4) @(negedge clk);
        check(rst_out == 1'b0, "R9", rst_out, 0);
        wait_apply();
        check(cur_div == 2'b01, "R10", cur_div, 1);

        // seeded random writes against the transition table (R3, R4)
        exp_div = 2'b01;
        for (int k = 0; k < 24; k++) begin
            logic [1:0] code;
            bit ok;
            code = 2'($urandom % 4);
            ok = move_ok(exp_div, code);
            if (ok) exp_div = code;
            wr(code, 1'b0);
            wait_apply();
            check(cur_div == exp_div, ok ? "R3" : "R4", cur_div, exp_div);
            if (k % 6 == 0)
                measure(ratio_of(exp_div), "R1");
        end

        done = 1'b1;
        finish_run();
    end

endmodule